// File: doc/BRIEF.md
# Descending Block Copy Engine

This block moves a run of bytes from one place in a 64 KiB byte memory to another. Work starts from the highest address of each region and moves downward. A single-cycle start pulse loads four values: a source pointer, a destination pointer, a byte count and an 8-bit flag word. The engine then runs on its own until the count is used up.

Each pass reads one byte at the source pointer. On the next cycle it writes that byte at the destination pointer. It then steps both pointers and the count down by one and updates the flag word. It also adds the pass's cycle cost, in T-states, to a running total. A pass that leaves a nonzero count is charged the longer cost and repeats. The pass that brings the count to zero is charged the shorter cost, and the engine then stops.

Because the copy runs downward, it gives the correct result when the destination overlaps the top of the source region. The final pointers, count, flags and T-state total stay on the outputs until the next start.

Top module: `desc_copy_engine`

## Requirements
- R1: A start pulse while idle loads source, destination, count and flags from the inputs and clears the T-state total. On the next cycle `busy_o` is high and a read of the source address is issued.
- R2: Each pass asserts `mem_rd_o` for one cycle with `mem_addr_o` equal to the source pointer. On the following cycle it asserts `mem_wr_o` with `mem_addr_o` equal to the destination pointer and `mem_wdata_o` equal to the byte returned with one cycle of latency. Read and write are never asserted in the same cycle.
- R3: In the cycle after each write, source, destination and count have each decreased by one, modulo 2^16.
- R4: After each pass, flag bits 7, 6 and 0 keep their loaded values, and bits 5, 4, 3 and 1 read zero. Bit 2 is 1 exactly when the count after the decrement is nonzero.
- R5: A pass that leaves the count nonzero adds 21 to the T-state total and is followed by another pass. The pass that leaves it zero adds 16 and ends the run. A count of N therefore totals 21*(N-1)+16.
- R6: A loaded count of 0 performs 65536 transfers, because the first decrement wraps it to 0xFFFF.
- R7: A start pulse while busy is ignored and does not change the transfer or its results.
- R8: `done_o` is high for exactly one cycle, the cycle in which `busy_o` first reads low after the final write.
- R9: When the destination lies above the source and the regions overlap, the destination region ends up holding the original source bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 16 | Initial byte count (0 means 65536) |
| flags_i | input | 8 | Initial flag word |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after read |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| cnt_o | output | 16 | Current count |
| flags_o | output | 8 | Current flag word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tstates_o | output | 32 | Accumulated T-state cost |

## Verification
The bench targets several corner cases, and each has a visible failure. A single-byte run exposes a cost or flag error: a design that charges the repeat cost, or leaves bit 2 set, reports 21 instead of 16. Pointers that start near zero must wrap to 0xFFFF. A design that saturates instead leaves the wrong bytes at the top of memory.

An overlapping copy with the destination one byte above the source goes wrong if the copy runs upward. In that case the run smears one byte across the whole region. A start pulse injected mid-run must be ignored. A design that reloads on it ends with the wrong pointers and cost.

A loaded count of zero must run the full 65536 passes. A design that treats zero as empty finishes after no writes.

// File: rtl/dcopy_pkg.sv
package dcopy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } dc_state_e;

  localparam int unsigned FB_C  = 0;
  localparam int unsigned FB_N  = 1;
  localparam int unsigned FB_PV = 2;
  localparam int unsigned FB_H  = 4;
  localparam int unsigned FB_Z  = 6;
  localparam int unsigned FB_S  = 7;

  localparam logic [7:0] KEEP_MASK = (8'h1 << FB_S) | (8'h1 << FB_Z) | (8'h1 << FB_C);
endpackage

// File: rtl/dcopy_fsm.sv
module dcopy_fsm
  import dcopy_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      last_i,
  output dc_state_e state_o,
  output logic      load_o,
  output logic      step_o,
  output logic      done_o
);
  dc_state_e state_q, state_d;
  logic      done_q;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = (state_q == ST_WR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_RD;
      ST_RD:   state_d = ST_WR;
      ST_WR:   state_d = last_i ? ST_IDLE : ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= step_o && last_i;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dcopy_dec_reg.sv
module dcopy_dec_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] init_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] val_q;

  assign nxt_o = val_q - W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= init_i;
    else if (step_i) val_q <= nxt_o;
  end

  assign val_o = val_q;
endmodule

// File: rtl/dcopy_flag_unit.sv
module dcopy_flag_unit
  import dcopy_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       step_i,
  input  logic [7:0] flags_i,
  input  logic       nz_i,
  output logic [7:0] flags_o
);
  logic [7:0] fl_q;
  logic [7:0] fl_step;

  always_comb begin
    fl_step        = fl_q & KEEP_MASK;
    fl_step[FB_PV] = nz_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fl_q <= '0;
    else if (load_i) fl_q <= flags_i;
    else if (step_i) fl_q <= fl_step;
  end

  assign flags_o = fl_q;
endmodule

// File: rtl/dcopy_tacc.sv
module dcopy_tacc #(
  parameter int unsigned TW        = 32,
  parameter int unsigned COST_RPT  = 21,
  parameter int unsigned COST_LAST = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          rpt_i,
  output logic [TW-1:0] tot_o
);
  logic [TW-1:0] tot_q;
  logic [TW-1:0] cost;

  assign cost = rpt_i ? TW'(COST_RPT) : TW'(COST_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tot_q <= '0;
    else if (clr_i)  tot_q <= '0;
    else if (step_i) tot_q <= tot_q + cost;
  end

  assign tot_o = tot_q;
endmodule

// File: rtl/desc_copy_engine.sv
module desc_copy_engine
  import dcopy_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned TW        = 32,
  parameter int unsigned COST_RPT  = 21,
  parameter int unsigned COST_LAST = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] cnt_i,
  input  logic [7:0]    flags_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [AW-1:0] cnt_o,
  output logic [7:0]    flags_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [TW-1:0] tstates_o
);
  localparam int unsigned NLANE = 3;
  localparam int unsigned L_SRC = 0;
  localparam int unsigned L_DST = 1;
  localparam int unsigned L_CNT = 2;

  dc_state_e state;
  logic      load, step, last, cnt_nz;

  logic [AW-1:0] lane_init [NLANE];
  logic [AW-1:0] lane_val  [NLANE];
  logic [AW-1:0] lane_nxt  [NLANE];

  assign lane_init[L_SRC] = src_i;
  assign lane_init[L_DST] = dst_i;
  assign lane_init[L_CNT] = cnt_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dcopy_dec_reg #(.W(AW)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .step_i (step),
      .init_i (lane_init[g]),
      .val_o  (lane_val[g]),
      .nxt_o  (lane_nxt[g])
    );
  end

  assign cnt_nz = |lane_nxt[L_CNT];
  assign last   = !cnt_nz;

  dcopy_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .last_i  (last),
    .state_o (state),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done_o)
  );

  dcopy_flag_unit u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .flags_i (flags_i),
    .nz_i    (cnt_nz),
    .flags_o (flags_o)
  );

  dcopy_tacc #(
    .TW        (TW),
    .COST_RPT  (COST_RPT),
    .COST_LAST (COST_LAST)
  ) u_tacc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .step_i (step),
    .rpt_i  (cnt_nz),
    .tot_o  (tstates_o)
  );

  assign mem_rd_o    = (state == ST_RD);
  assign mem_wr_o    = (state == ST_WR);
  assign mem_addr_o  = mem_wr_o ? lane_val[L_DST] : lane_val[L_SRC];
  assign mem_wdata_o = mem_rdata_i;

  assign src_o  = lane_val[L_SRC];
  assign dst_o  = lane_val[L_DST];
  assign cnt_o  = lane_val[L_CNT];
  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/dcopy_chk.sv
module dcopy_chk
  import dcopy_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned TW        = 32,
  parameter int unsigned COST_RPT  = 21,
  parameter int unsigned COST_LAST = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] cnt_i,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [AW-1:0] src_o,
  input logic [AW-1:0] dst_o,
  input logic [AW-1:0] cnt_o,
  input logic [7:0]    flags_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [TW-1:0] tstates_o
);
  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && mem_rd_o && cnt_o == $past(cnt_i) && tstates_o == '0));

  p_rd_wr_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_wr_after_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mem_wr_o);

  p_ptr_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (src_o == AW'($past(src_o) - 1'b1) && dst_o == AW'($past(dst_o) - 1'b1)
                  && cnt_o == AW'($past(cnt_o) - 1'b1)));

  p_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ((flags_o & KEEP_MASK) == ($past(flags_o) & KEEP_MASK)
                  && flags_o[FB_H] == 1'b0 && flags_o[FB_N] == 1'b0
                  && flags_o[5] == 1'b0 && flags_o[3] == 1'b0
                  && flags_o[FB_PV] == (cnt_o != '0)));

  p_cost_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> tstates_o == $past(tstates_o) + ((cnt_o != '0) ? TW'(COST_RPT) : TW'(COST_LAST)));

  p_ignore_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mem_rd_o) |=> ($stable(cnt_o) && $stable(src_o) && $stable(dst_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(mem_wr_o)));
endmodule

bind desc_copy_engine dcopy_chk #(
  .AW        (AW),
  .TW        (TW),
  .COST_RPT  (COST_RPT),
  .COST_LAST (COST_LAST)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .cnt_i     (cnt_i),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .src_o     (src_o),
  .dst_o     (dst_o),
  .cnt_o     (cnt_o),
  .flags_o   (flags_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .tstates_o (tstates_o)
);

// File: tb/desc_copy_engine_tb_top.sv
module desc_copy_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] src = '0, dst = '0, cnt = '0;
  logic [7:0]  flg = '0;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] src_q, dst_q, cnt_q;
  logic [7:0]  flg_q;
  logic        busy, done;
  logic [31:0] tst;

  logic        fill_req = 1'b0;
  logic [7:0]  mem      [0:65535];
  logic [7:0]  ref_mem  [0:65535];
  logic [7:0]  orig_mem [0:65535];

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  desc_copy_engine dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .src_i       (src),
    .dst_i       (dst),
    .cnt_i       (cnt),
    .flags_i     (flg),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .src_o       (src_q),
    .dst_o       (dst_q),
    .cnt_o       (cnt_q),
    .flags_o     (flg_q),
    .busy_o      (busy),
    .done_o      (done),
    .tstates_o   (tst)
  );

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 65536; i++) mem[i] <= 8'($urandom);
    end else begin
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic longint cost_of(input int n);
    return 21 * longint'(n - 1) + 16;
  endfunction

  task automatic run_copy(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                          input logic [7:0] f, input bit inject, input bit chk_overlap);
    int          n;
    int          cyc;
    int          wrs;
    int          excl;
    bit          prev_wr;
    bit          got_mid;
    bit          got_first;
    logic [7:0]  mid_f;
    logic [15:0] mid_c;
    logic [15:0] fw_addr;
    logic [7:0]  fw_data;
    int          mism;
    n = (c == 16'h0) ? 65536 : int'(c);
    for (int i = 0; i < 65536; i++) orig_mem[i] = mem[i];
    for (int i = 0; i < 65536; i++) ref_mem[i] = mem[i];
    for (int i = 0; i < n; i++) ref_mem[16'(d - 16'(i))] = ref_mem[16'(s - 16'(i))];

    @(negedge clk);
    start = 1'b1; src = s; dst = d; cnt = c; flg = f;
    @(negedge clk);
    start = 1'b0; src = 16'($urandom); dst = 16'($urandom); cnt = 16'($urandom); flg = 8'($urandom);
    chk(busy && mem_rd, "R1 busy and read after start", {busy, mem_rd}, 2'b11);
    chk(mem_addr == s, "R2 first read address", mem_addr, s);
    chk(tst == 32'd0, "R1 total cleared", tst, 0);

    cyc = 0; wrs = 0; excl = 0; prev_wr = 0; got_mid = 0; got_first = 0;
    mid_f = '0; mid_c = '0; fw_addr = '0; fw_data = '0;
    while (1) begin
      if (prev_wr && !got_mid) begin
        mid_f = flg_q; mid_c = cnt_q; got_mid = 1;
      end
      if (done) break;
      if (cyc > 2 * n + 20) break;
      if (mem_rd && mem_wr) excl++;
      if (mem_wr) begin
        wrs++;
        if (!got_first) begin
          fw_addr = mem_addr; fw_data = mem_wdata; got_first = 1;
        end
      end
      prev_wr = mem_wr;
      start = (inject && cyc == 3);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;

    chk(done, "R8 done seen", done, 1);
    chk(!busy, "R8 busy low with done", busy, 0);
    chk(excl == 0, "R2 read/write exclusive", excl, 0);
    chk(fw_addr == d, "R2 first write address", fw_addr, d);
    chk(fw_data == orig_mem[s], "R2 first write data", fw_data, orig_mem[s]);
    chk(wrs == n, "R6 transfer count", wrs, n);
    chk(mid_c == 16'(c - 16'h1), "R3 count after first pass", mid_c, 16'(c - 16'h1));
    chk(mid_f == ((f & 8'hC1) | ((n > 1) ? 8'h04 : 8'h00)), "R4 flags after first pass",
        mid_f, (f & 8'hC1) | ((n > 1) ? 8'h04 : 8'h00));
    chk(src_q == 16'(s - 16'(n)), "R3 final source", src_q, 16'(s - 16'(n)));
    chk(dst_q == 16'(d - 16'(n)), "R3 final destination", dst_q, 16'(d - 16'(n)));
    chk(cnt_q == 16'h0, "R3 final count", cnt_q, 0);
    chk(flg_q == (f & 8'hC1), "R4 final flags", flg_q, f & 8'hC1);
    chk(longint'(tst) == cost_of(n), "R5 T-state total", tst, cost_of(n));
    if (inject) chk(src_q == 16'(s - 16'(n)) && wrs == n, "R7 start while busy ignored", wrs, n);
    mism = 0;
    for (int i = 0; i < 65536; i++) if (mem[i] !== ref_mem[i]) mism++;
    chk(mism == 0, "R9 memory image", mism, 0);
    if (chk_overlap) begin
      mism = 0;
      for (int i = 0; i < n; i++)
        if (mem[16'(d - 16'(i))] !== orig_mem[16'(s - 16'(i))]) mism++;
      chk(mism == 0, "R9 overlap destination holds source", mism, 0);
    end
    @(negedge clk);
    chk(!done && !busy, "R8 done one cycle", {done, busy}, 0);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED1));
    fork
      begin
        fill_req = 1'b1;
        repeat (3) @(negedge clk);
        fill_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R8 reset idle", {busy, done, mem_rd, mem_wr}, 0);
        chk(tst == 32'd0 && cnt_q == 16'h0, "R1 reset values", tst, 0);
        run_copy(16'h4010, 16'h8010, 16'h0001, 8'hFF, 1'b0, 1'b0);
        run_copy(16'h2007, 16'h2008, 16'h0008, 8'h3E, 1'b0, 1'b1);
        run_copy(16'h0003, 16'h0001, 16'h0006, 8'hC5, 1'b0, 1'b0);
        run_copy(16'h1234, 16'hA000, 16'h0010, 8'h81, 1'b1, 1'b0);
        for (int k = 0; k < 12; k++) begin
          logic [15:0] rs;
          logic [15:0] rd;
          rs = 16'($urandom);
          rd = (k % 2 == 0) ? 16'(rs + 16'($urandom_range(1, 8))) : 16'($urandom);
          run_copy(rs, rd, 16'($urandom_range(1, 32)), 8'($urandom), 1'b0, 1'b0);
        end
        run_copy(16'h00FF, 16'h00FF, 16'h0000, 8'h41, 1'b0, 1'b0);
      end
      begin
        repeat (199000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 199000, 0);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule